// File: doc/BRIEF.md
# Debug Operation Sequencer

This block turns a single high-level debug request into the byte traffic that a small 8-bit target's debug port expects. It sits above a byte-wide link master that owns bit timing. Some requests are one command byte, optionally followed by a value byte, and then one or two reply bytes: halt, resume, single step, status, program counter, chip identifier, configuration read and write, and chip erase.

Memory peeks and pokes, and setting the program counter, are built differently. They are a short run of target instructions, each sent with an "inject instruction" command. That command byte carries the instruction length in its two low bits. The block supports external data memory, internal RAM and banked code memory.

A request is offered with `req_valid` while `busy` is low. The block raises `busy` until the sequence ends. It then pulses `done` for one cycle, and at that point `result` and `err` are valid. The link side is a simple request/acknowledge port. The sequencer holds `lk_valid` with a stable byte and direction until the link pulses `lk_ready`. On a read, `lk_rdata` is taken in that same cycle.

Top module: `dbgop_sequencer`

## Requirements
- R1: Operation codes 0 halt, 1 resume, 2 step, 3 status, 6 config read and 8 erase each send one command byte (0x44, 0x4C, 0x5C, 0x3F, 0x24, 0x14 respectively), read one reply byte and return it as result {0x00, reply}.
- R2: Operation codes 4 (program counter, command 0x28) and 5 (chip identifier, command 0x68) read two reply bytes and return {first reply, second reply}.
- R3: Every injected instruction is sent as header byte 0x54 plus its length (1 to 3), then exactly that many instruction bytes, then one reply read. No unused slot byte is sent.
- R4: Operation 10 (data memory write) injects {0x90, addr[15:8], addr[7:0]}, then {0x74, value}, then {0xF0}. The result is the last reply.
- R5: Operation 9 (data memory read) injects {0x90, addr[15:8], addr[7:0]} and then {0xE0}. The result is {0x00, reply to the 0xE0 injection}.
- R6: Operation 13 (code memory read) injects {0x75, 0xC7, bank*16+1}, where bank is addr bits 17:15. It then injects {0x90, addr[15:8], addr[7:0]}, {0xE4} and {0x93}. The result is the reply to 0x93.
- R7: Operation 11 (internal RAM read) injects {0xE4} and then {0xE5, addr[7:0]}. Operation 12 (internal RAM write) injects {0xE4} and then {0x75, addr[7:0], value}. The result is the last reply.
- R8: Operation 14 (set program counter) injects {0x02, addr[15:8], addr[7:0]}.
- R9: Operation 7 (config write) sends 0x1D, then the value byte, then reads one reply.
- R10: Operation code 15 is unsupported. `done` pulses with `err` set in the cycle after acceptance, and there is no link activity.
- R11: A request is taken only while `busy` is low, and requests offered while busy are ignored. `busy` stays high until `done`, and `done` lasts one cycle. `lk_valid` is asserted only while busy. While `lk_valid` is high and `lk_ready` is low, the byte and direction hold steady.
- R12: After reset `busy`, `done`, `err` and `lk_valid` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered (taken when busy is low) |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Target address |
| req_data | input | 8 | Value for write operations |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported operation, valid with done |
| result | output | 16 | Reply value, valid with done |
| lk_valid | output | 1 | Link byte transfer requested |
| lk_write | output | 1 | 1 = send lk_wdata, 0 = receive a byte |
| lk_wdata | output | 8 | Byte to send |
| lk_ready | input | 1 | Link completes the current transfer |
| lk_rdata | input | 8 | Received byte, valid with lk_ready on a read |

## Verification
Two things can fall in the same cycle. A link acknowledge that finishes one injected instruction also starts the next instruction's header byte. The same edge that completes the final reply also ends the sequence. The bench provokes both by acknowledging after a random 0 to 2 cycle delay, so back-to-back acknowledges land exactly on step boundaries. It judges them by comparing the full captured byte stream with a stream the bench builds itself, and by checking which reply ends up in `result`. A further directed case keeps `req_valid` asserted while busy, to show that a new request arriving during a sequence is ignored.

// File: rtl/dbgseq_pkg.sv
// Package: shared operation codes, step descriptor and step builders.
// Assumes instruction lengths of 1..3 bytes and command bytes of 8 bits.
package dbgseq_pkg;

    typedef enum logic [3:0] {
        OP_HALT   = 4'd0,
        OP_RESUME = 4'd1,
        OP_STEP   = 4'd2,
        OP_STATUS = 4'd3,
        OP_GETPC  = 4'd4,
        OP_CHIPID = 4'd5,
        OP_CFGRD  = 4'd6,
        OP_CFGWR  = 4'd7,
        OP_ERASE  = 4'd8,
        OP_XRD    = 4'd9,
        OP_XWR    = 4'd10,
        OP_IRD    = 4'd11,
        OP_IWR    = 4'd12,
        OP_CODERD = 4'd13,
        OP_SETPC  = 4'd14
    } dbg_op_e;

    localparam logic [7:0] CMD_INJECT = 8'h54;

    // One link step: header, 0..3 payload bytes, one or two replies.
    typedef struct packed {
        logic [7:0] hdr;
        logic [1:0] nb;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic       two_rep;
    } step_t;

    // Known operation codes are 0..14.
    function automatic logic op_known(input logic [3:0] op);
        return op != 4'hF;
    endfunction

    // Build an injected-instruction step (length carried in the header).
    function automatic step_t inj(input logic [1:0] len, input logic [7:0] a,
                                  input logic [7:0] b, input logic [7:0] c);
        step_t s;
        s.hdr     = CMD_INJECT + {6'd0, len};
        s.nb      = len;
        s.b0      = a;
        s.b1      = b;
        s.b2      = c;
        s.two_rep = 1'b0;
        return s;
    endfunction

    // Build a plain command step.
    function automatic step_t plain(input logic [7:0] code, input logic [1:0] nb,
                                    input logic [7:0] a, input logic two);
        step_t s;
        s.hdr     = code;
        s.nb      = nb;
        s.b0      = a;
        s.b1      = 8'h00;
        s.b2      = 8'h00;
        s.two_rep = two;
        return s;
    endfunction

endpackage

// File: rtl/dbgseq_plan.sv
// Module: maps (operation, address, value, step index) to one link step and
// reports the index of the last step. Purely combinational.
// Assumes ADDR_W >= 16; code bank is taken from the address bits above 14.
module dbgseq_plan
    import dbgseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic [1:0]        idx,
    output step_t             step,
    output logic [1:0]        last_idx
);
    localparam int BANK_W = (ADDR_W - 15 > 4) ? 4 : ADDR_W - 15;

    logic [7:0] hi, lo, bank_b;
    logic [3:0] bank;

    // Address bytes and the memory-control value for the code bank.
    always_comb begin
        hi     = addr[15:8];
        lo     = addr[7:0];
        bank   = 4'(addr[15 +: BANK_W]);
        bank_b = {bank, 4'h1};
    end

    // Step selection per operation.
    always_comb begin
        step     = '0;
        last_idx = 2'd0;
        case (dbg_op_e'(op))
            OP_HALT:   step = plain(8'h44, 2'd0, 8'h00, 1'b0);
            OP_RESUME: step = plain(8'h4C, 2'd0, 8'h00, 1'b0);
            OP_STEP:   step = plain(8'h5C, 2'd0, 8'h00, 1'b0);
            OP_STATUS: step = plain(8'h3F, 2'd0, 8'h00, 1'b0);
            OP_GETPC:  step = plain(8'h28, 2'd0, 8'h00, 1'b1);
            OP_CHIPID: step = plain(8'h68, 2'd0, 8'h00, 1'b1);
            OP_CFGRD:  step = plain(8'h24, 2'd0, 8'h00, 1'b0);
            OP_CFGWR:  step = plain(8'h1D, 2'd1, data,  1'b0);
            OP_ERASE:  step = plain(8'h14, 2'd0, 8'h00, 1'b0);
            OP_XRD: begin
                last_idx = 2'd1;
                step = (idx == 2'd0) ? inj(2'd3, 8'h90, hi, lo)
                                     : inj(2'd1, 8'hE0, 8'h00, 8'h00);
            end
            OP_XWR: begin
                last_idx = 2'd2;
                case (idx)
                    2'd0:    step = inj(2'd3, 8'h90, hi, lo);
                    2'd1:    step = inj(2'd2, 8'h74, data, 8'h00);
                    default: step = inj(2'd1, 8'hF0, 8'h00, 8'h00);
                endcase
            end
            OP_IRD: begin
                last_idx = 2'd1;
                step = (idx == 2'd0) ? inj(2'd1, 8'hE4, 8'h00, 8'h00)
                                     : inj(2'd2, 8'hE5, lo, 8'h00);
            end
            OP_IWR: begin
                last_idx = 2'd1;
                step = (idx == 2'd0) ? inj(2'd1, 8'hE4, 8'h00, 8'h00)
                                     : inj(2'd3, 8'h75, lo, data);
            end
            OP_CODERD: begin
                last_idx = 2'd3;
                case (idx)
                    2'd0:    step = inj(2'd3, 8'h75, 8'hC7, bank_b);
                    2'd1:    step = inj(2'd3, 8'h90, hi, lo);
                    2'd2:    step = inj(2'd1, 8'hE4, 8'h00, 8'h00);
                    default: step = inj(2'd1, 8'h93, 8'h00, 8'h00);
                endcase
            end
            OP_SETPC:  step = inj(2'd3, 8'h02, hi, lo);
            default:   step = '0;
        endcase
    end

endmodule

// File: rtl/dbgseq_link.sv
// Module: walks one step byte by byte on the link: header, payload, replies.
// Assumes the step descriptor is stable while en is high and the link
// completes a transfer with a one-cycle lk_ready pulse.
module dbgseq_link
    import dbgseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  step_t      step,
    input  logic       lk_ready,
    output logic       lk_valid,
    output logic       lk_write,
    output logic [7:0] lk_wdata,
    output logic       rep_stb,
    output logic       rep_first,
    output logic       step_done
);
    logic [2:0] cnt;
    logic [2:0] nb3;
    logic [2:0] last;
    logic       is_read;

    // Byte position decode for the current step.
    always_comb begin
        nb3     = {1'b0, step.nb};
        last    = nb3 + (step.two_rep ? 3'd2 : 3'd1);
        is_read = cnt > nb3;
        case (cnt)
            3'd0:    lk_wdata = step.hdr;
            3'd1:    lk_wdata = step.b0;
            3'd2:    lk_wdata = step.b1;
            3'd3:    lk_wdata = is_read ? 8'h00 : step.b2;
            default: lk_wdata = 8'h00;
        endcase
        lk_valid  = en;
        lk_write  = !is_read;
        step_done = en && lk_ready && (cnt == last);
        rep_stb   = en && lk_ready && is_read;
        rep_first = (cnt == nb3 + 3'd1);
    end

    // Byte position counter; restarts at each step boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= 3'd0;
        end else if (lk_ready) begin
            cnt <= (cnt == last) ? 3'd0 : cnt + 3'd1;
        end
    end

endmodule

// File: rtl/dbgop_sequencer.sv
// Module: top-level debug operation sequencer. Accepts one request while
// idle, runs its steps through the link walker, collects the final reply.
// Assumes the link master handles bit timing and direction turnaround.
module dbgop_sequencer
    import dbgseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [15:0]       result,
    output logic              lk_valid,
    output logic              lk_write,
    output logic [7:0]        lk_wdata,
    input  logic              lk_ready,
    input  logic [7:0]        lk_rdata
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

    state_e            state;
    logic [3:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [1:0]        idx_q;
    logic              err_q;
    logic [15:0]       res_q;
    step_t             step;
    logic [1:0]        last_idx;
    logic              rep_stb, rep_first, step_done;

    dbgseq_plan #(.ADDR_W(ADDR_W)) plan_i (
        .op       (op_q),
        .addr     (addr_q),
        .data     (data_q),
        .idx      (idx_q),
        .step     (step),
        .last_idx (last_idx)
    );

    dbgseq_link link_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state == S_RUN),
        .step      (step),
        .lk_ready  (lk_ready),
        .lk_valid  (lk_valid),
        .lk_write  (lk_write),
        .lk_wdata  (lk_wdata),
        .rep_stb   (rep_stb),
        .rep_first (rep_first),
        .step_done (step_done)
    );

    // Request acceptance, step sequencing and reply collection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= 4'd0;
            addr_q <= '0;
            data_q <= 8'd0;
            idx_q  <= 2'd0;
            err_q  <= 1'b0;
            res_q  <= 16'd0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    op_q   <= req_op;
                    addr_q <= req_addr;
                    data_q <= req_data;
                    idx_q  <= 2'd0;
                    res_q  <= 16'd0;
                    err_q  <= !op_known(req_op);
                    state  <= op_known(req_op) ? S_RUN : S_FIN;
                end
                S_RUN: begin
                    if (rep_stb) begin
                        res_q <= rep_first ? {8'h00, lk_rdata} : {res_q[7:0], lk_rdata};
                    end
                    if (step_done) begin
                        if (idx_q == last_idx) state <= S_FIN;
                        else                   idx_q <= idx_q + 2'd1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output mapping.
    always_comb begin
        busy   = (state != S_IDLE);
        done   = (state == S_FIN);
        err    = err_q;
        result = res_q;
    end

endmodule

// File: rtl/dbgop_sequencer_chk.sv
// Checker: port-level protocol properties of the sequencer, bound to the top.
module dbgop_sequencer_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        req_op,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              lk_valid,
    input logic              lk_write,
    input logic [7:0]        lk_wdata,
    input logic              lk_ready
);
    AST_LK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_ready |=> lk_valid && $stable(lk_wdata) && $stable(lk_write)); // R11
    AST_LK_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> busy); // R11
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy |=> busy); // R11
    AST_UNSUP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && req_op == 4'hF |=> done && err && !lk_valid); // R10
    AST_OK_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> !err); // R10
endmodule

bind dbgop_sequencer dbgop_sequencer_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .lk_valid  (lk_valid),
    .lk_write  (lk_write),
    .lk_wdata  (lk_wdata),
    .lk_ready  (lk_ready)
);

// File: tb/dbgop_sequencer_tb_top.sv
module dbgop_sequencer_tb_top;
    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [3:0]        req_op = 4'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_data = 8'd0;
    logic              busy, done, err;
    logic [15:0]       result;
    logic              lk_valid, lk_write;
    logic [7:0]        lk_wdata;
    logic              lk_ready = 1'b0;
    logic [7:0]        lk_rdata = 8'd0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int dly = 0;
    int wq[$];
    int rq[$];
    int eq[$];

    dbgop_sequencer #(.ADDR_W(ADDR_W)) dut_i (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                finish_run();
            end
        end
    end

    // Link responder: random 0..2 cycle acknowledge delay, logs the stream.
    initial begin
        forever begin
            @(negedge clk);
            if (lk_ready) begin
                lk_ready = 1'b0;
                dly = $urandom % 3;
            end else if (lk_valid) begin
                if (dly == 0) begin
                    lk_ready = 1'b1;
                    if (lk_write) wq.push_back(int'(lk_wdata));
                    else begin
                        lk_rdata = 8'($urandom);
                        wq.push_back(-1);
                        rq.push_back(int'(lk_rdata));
                    end
                end else dly--;
            end
        end
    end

    task automatic inj(input int len, input int a, input int b, input int c);
        eq.push_back(8'h54 + len);
        eq.push_back(a);
        if (len > 1) eq.push_back(b);
        if (len > 2) eq.push_back(c);
        eq.push_back(-1);
    endtask

    task automatic plain(input int code, input bit two);
        eq.push_back(code);
        eq.push_back(-1);
        if (two) eq.push_back(-1);
    endtask

    // Expected byte stream from the requirements (-1 marks a reply read).
    task automatic build(input int op, input int addr, input int data);
        int hi = (addr >> 8) & 8'hFF;
        int lo = addr & 8'hFF;
        int bank = (addr >> 15) & 7;
        eq.delete();
        case (op)
            0: plain(8'h44, 0);
            1: plain(8'h4C, 0);
            2: plain(8'h5C, 0);
            3: plain(8'h3F, 0);
            4: plain(8'h28, 1);
            5: plain(8'h68, 1);
            6: plain(8'h24, 0);
            7: begin eq.push_back(8'h1D); eq.push_back(data); eq.push_back(-1); end
            8: plain(8'h14, 0);
            9: begin inj(3, 8'h90, hi, lo); inj(1, 8'hE0, 0, 0); end
            10: begin inj(3, 8'h90, hi, lo); inj(2, 8'h74, data, 0); inj(1, 8'hF0, 0, 0); end
            11: begin inj(1, 8'hE4, 0, 0); inj(2, 8'hE5, lo, 0); end
            12: begin inj(1, 8'hE4, 0, 0); inj(3, 8'h75, lo, data); end
            13: begin inj(3, 8'h75, 8'hC7, bank * 16 + 1); inj(3, 8'h90, hi, lo);
                      inj(1, 8'hE4, 0, 0); inj(1, 8'h93, 0, 0); end
            14: inj(3, 8'h02, hi, lo);
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0, 1, 2, 3, 6, 8: return "R1";
            4, 5:  return "R2";
            7:     return "R9";
            9:     return "R5 R3";
            10:    return "R4 R3";
            11, 12: return "R7 R3";
            13:    return "R6 R3";
            14:    return "R8 R3";
            default: return "R10";
        endcase
    endfunction

    task automatic run_op(input int op, input int addr, input int data, input bit poke);
        int n;
        bit same;
        int exp_res;
        while (busy) @(negedge clk);
        wq.delete();
        rq.delete();
        build(op, addr, data);
        req_op = 4'(op);
        req_addr = ADDR_W'(addr);
        req_data = 8'(data);
        req_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            req_op = 4'hF;
            @(negedge clk);
            @(negedge clk);
            chk(busy, "R11 busy held", int'(busy), 1);
        end
        req_valid = 1'b0;
        if (op == 15) begin
            chk(done && err, "R10 done+err next cycle", int'({done, err}), 3);
            chk(wq.size() == 0, "R10 no link bytes", wq.size(), 0);
            @(negedge clk);
            chk(!busy && !done, "R11 idle after done", int'({busy, done}), 0);
            return;
        end
        while (!done) @(negedge clk);
        same = (wq.size() == eq.size());
        n = wq.size();
        if (same) foreach (eq[i]) if (wq[i] != eq[i]) same = 0;
        chk(same, {tag_of(op), " stream"}, n, eq.size());
        if (!same) foreach (wq[i]) $display("  got[%0d]=%0h", i, wq[i]);
        if (op == 4 || op == 5) exp_res = (rq[rq.size()-2] << 8) | rq[rq.size()-1];
        else exp_res = rq[rq.size()-1];
        chk(int'(result) == exp_res, {tag_of(op), " result"}, int'(result), exp_res);
        chk(!err, {tag_of(op), " no err"}, int'(err), 0);
        @(negedge clk);
        chk(!done, "R11 done one cycle", int'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R12: reset state.
        chk(!busy && !done && !err && !lk_valid && result == 16'd0, "R12 reset",
            int'({busy, done, err, lk_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners.
        for (int op = 0; op < 16; op++) run_op(op, 18'h2A5C3, 8'h5A, 1'b0);
        run_op(13, 18'h3FFFF, 8'h00, 1'b0);   // R6 highest bank
        run_op(13, 18'h00000, 8'h00, 1'b0);   // R6 bank zero
        run_op(10, 18'h0FFFF, 8'hFF, 1'b1);   // R11 request while busy ignored
        run_op(12, 18'h000FF, 8'h01, 1'b0);   // R7 address edge
        // Random mix.
        for (int k = 0; k < 80; k++)
            run_op(int'($urandom % 16), int'($urandom % (1 << ADDR_W)), int'($urandom % 256), 1'b0);
        finish_run();
    end

endmodule